// File: doc/BRIEF.md
# Up-Down PWM Generator with Cycle-by-Cycle Trip

This block produces one PWM output from a symmetric triangle time base. A counter climbs from zero to a programmed period value and then falls back to zero, so one PWM period lasts twice the period value in clocks. The output goes high when the counter meets the compare value on the way up. It goes low when the counter meets the compare value on the way down. The result is a centre-aligned pulse whose width shrinks as the compare value grows.

Two override paths sit on top of this compare logic, and they behave differently. A one-shot software force writes a new level into the compare-driven output state, and the next compare match replaces it as usual. A cycle-by-cycle trip comes from a hardware trip input or a software trip strobe. It latches, and holds the output at a configured level until the counter next reaches zero. The next PWM cycle then starts clean, unless the trip condition is still present.

A trip also raises a sticky trip flag, which software clears through a clear strobe. A prescaled period interrupt gives one pulse after every Nth counter-equals-period event. Period and compare values pass through shadow registers and take effect only when the counter is at zero.

Top module: `updn_pwm_trip`

## Requirements
- R1: After a new period value P (P ≥ 1) is taken up, `ctrOut` follows 1, 2, …, P, P−1, …, 0 and repeats, so one cycle is 2·P clocks.
- R2: Values on `periodIn` and `compareIn` are copied into the active registers only on a clock where the counter is zero. A change made mid-cycle leaves the running cycle's peak and edges unchanged.
- R3: The internal compare state goes high on a clock where the counter equals the compare value C while counting up, and low where it equals C while counting down. With no trip, `pwmOut` shows this state from the following clock.
- R4: A one-clock pulse on `swForce` loads `swForceLevel` into the compare state from the next clock, provided no compare match occurs in that clock (a match wins). Later compare matches act normally.
- R5: A trip request (`tripIn` high or a `tripForce` pulse) latches a trip from the next clock. While the trip is latched, `pwmOut` follows the `tripAction` code: 2'b01 forces high, 2'b10 forces low, and 2'b00 or 2'b11 leaves the compare state on the output.
- R6: A latched trip is released by the clock in which the counter is zero, and the compare state drives `pwmOut` from the clock after. If a trip request is present in that zero clock, the trip latches again and the override continues.
- R7: `tripFlag` goes high the clock after any trip request and stays high until a `tripFlagClr` pulse. A request in the same clock as a clear keeps the flag set.
- R8: With `intEnable` high and `intPrescale` = N (1..3), `periodIrq` pulses high for one clock, one clock after every Nth counter-equals-period event. With N = 0 it never pulses.
- R9: Whenever `intEnable` is low, the period-event count returns to zero, and counting starts afresh once the interrupt is enabled again.
- R10: During and right after reset, `ctrOut`, `pwmOut`, `tripFlag` and `periodIrq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodIn | input | CNT_W | Shadow period value (peak of the triangle) |
| compareIn | input | CNT_W | Shadow compare value |
| tripIn | input | 1 | Hardware trip request, level |
| tripForce | input | 1 | Software trip request, one-clock strobe |
| tripAction | input | 2 | Output under trip: 01 high, 10 low, 00/11 unchanged |
| swForce | input | 1 | One-shot software output force strobe |
| swForceLevel | input | 1 | Level loaded by `swForce` |
| tripFlagClr | input | 1 | Clears the trip flag |
| intEnable | input | 1 | Period interrupt enable; low resets the event count |
| intPrescale | input | PRESC_W | Period events per interrupt; 0 disables |
| ctrOut | output | CNT_W | Time-base counter value |
| pwmOut | output | 1 | PWM output |
| tripFlag | output | 1 | Sticky trip flag |
| periodIrq | output | 1 | One-clock prescaled period interrupt |

## Verification
Some rules are checked on every clock. The counter moves by exactly one step away from zero, the active values change only on zero clocks, and a high or low trip action overrides the output on the next clock. A trip request always sets the flag, compare matches drive the compare state, a release at zero hands the output back to that state, and the interrupt never lasts two clocks. The bench scenarios show what a single-clock property cannot: the exact triangle and pulse shape across a sweep of periods and compare values, the unchanged peak after a mid-cycle period write, a forced level that the next compare match undoes, a trip held through a zero by a level input, and the interrupt spacing after the counter is reset by disabling the interrupt.

// File: rtl/updn_pwm_pkg.sv
package updn_pwm_pkg;
  // Time-base events handed from the counter datapath to the control logic
  typedef struct packed {
    logic atZero;
    logic atPeriod;
    logic cmpUp;
    logic cmpDown;
  } tbEvt_t;

  // Trip output action codes
  localparam logic [1:0] TRIP_ACT_HIGH = 2'b01;
  localparam logic [1:0] TRIP_ACT_LOW  = 2'b10;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import updn_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] compareIn,
  output logic [CNT_W-1:0] ctr,
  output tbEvt_t           evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prdAct;
  logic [CNT_W-1:0] cmpAct;
  logic             dirUp;
  logic             atZero;
  logic             prdLive;

  assign atZero  = (cnt == '0);
  assign prdLive = (prdAct != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      dirUp  <= 1'b0;
      prdAct <= '0;
      cmpAct <= '0;
    end else begin
      if (atZero) begin
        prdAct <= periodIn;
        cmpAct <= compareIn;
      end
      if (atZero) begin
        if (!prdLive) begin
          cnt   <= '0;
          dirUp <= 1'b0;
        end else begin
          cnt   <= cnt + 1'b1;
          dirUp <= 1'b1;
        end
      end else if (dirUp && (cnt >= prdAct)) begin
        cnt   <= cnt - 1'b1;
        dirUp <= 1'b0;
      end else if (dirUp) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign ctr          = cnt;
  assign evt.atZero   = atZero;
  assign evt.atPeriod = dirUp && (cnt == prdAct) && prdLive;
  assign evt.cmpUp    = dirUp && (cnt == cmpAct) && prdLive;
  assign evt.cmpDown  = !dirUp && (cnt == cmpAct) && prdLive;

  // R1: away from zero the counter always moves by exactly one step
  assert_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

  // R2: active period and compare change only after a zero clock
  assert_shadow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!atZero) |=> ($stable(prdAct) && $stable(cmpAct)));
endmodule

// File: rtl/pwm_control.sv
module pwm_control
  import updn_pwm_pkg::*;
#(
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tbEvt_t             evt,
  input  logic               tripIn,
  input  logic               tripForce,
  input  logic [1:0]         tripAction,
  input  logic               swForce,
  input  logic               swForceLevel,
  input  logic               tripFlagClr,
  input  logic               intEnable,
  input  logic [PRESC_W-1:0] intPrescale,
  output logic               pwmOut,
  output logic               tripFlag,
  output logic               periodIrq
);
  logic               aqOut;
  logic               aqNext;
  logic               tripLatch;
  logic               latchNext;
  logic               tripReq;
  logic               overrideOn;
  logic               pwmNext;
  logic [PRESC_W-1:0] evtCnt;
  logic [PRESC_W-1:0] evtCntInc;

  assign tripReq   = tripIn | tripForce;
  assign evtCntInc = evtCnt + 1'b1;

  // Compare-driven state: compare matches take priority over the one-shot force
  always_comb begin
    aqNext = aqOut;
    if (evt.cmpUp)        aqNext = 1'b1;
    else if (evt.cmpDown) aqNext = 1'b0;
    else if (swForce)     aqNext = swForceLevel;
  end

  // Trip latch: dropped at counter zero, re-taken if a request is present
  always_comb begin
    if (evt.atZero) latchNext = tripReq;
    else            latchNext = tripLatch | tripReq;
  end

  always_comb begin
    overrideOn = latchNext &&
                 ((tripAction == TRIP_ACT_HIGH) || (tripAction == TRIP_ACT_LOW));
    pwmNext    = overrideOn ? (tripAction == TRIP_ACT_HIGH) : aqNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aqOut     <= 1'b0;
      tripLatch <= 1'b0;
      pwmOut    <= 1'b0;
      tripFlag  <= 1'b0;
    end else begin
      aqOut     <= aqNext;
      tripLatch <= latchNext;
      pwmOut    <= pwmNext;
      if (tripReq)          tripFlag <= 1'b1;
      else if (tripFlagClr) tripFlag <= 1'b0;
    end
  end

  // Period-event prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtCnt    <= '0;
      periodIrq <= 1'b0;
    end else begin
      periodIrq <= 1'b0;
      if (!intEnable) begin
        evtCnt <= '0;
      end else if (evt.atPeriod) begin
        if ((intPrescale != '0) && (evtCntInc == intPrescale)) begin
          periodIrq <= 1'b1;
          evtCnt    <= '0;
        end else begin
          evtCnt <= evtCntInc;
        end
      end
    end
  end

  // R3: compare matches drive the compare state
  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    evt.cmpUp |=> aqOut);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    evt.cmpDown |=> !aqOut);

  // R5: high and low trip actions override the output on the next clock
  assert_trip_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tripReq && (tripAction == TRIP_ACT_HIGH)) |=> pwmOut);
  assert_trip_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tripReq && (tripAction == TRIP_ACT_LOW)) |=> !pwmOut);

  // R6: a zero clock with no request hands the output back to the compare state
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evt.atZero && !tripReq) |=> (pwmOut == aqOut));

  // R7: any trip request sets the flag
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    tripReq |=> tripFlag);

  // R8: the interrupt is a single-clock pulse
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |=> !periodIrq);
endmodule

// File: rtl/updn_pwm_trip.sv
module updn_pwm_trip
  import updn_pwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   periodIn,
  input  logic [CNT_W-1:0]   compareIn,
  input  logic               tripIn,
  input  logic               tripForce,
  input  logic [1:0]         tripAction,
  input  logic               swForce,
  input  logic               swForceLevel,
  input  logic               tripFlagClr,
  input  logic               intEnable,
  input  logic [PRESC_W-1:0] intPrescale,
  output logic [CNT_W-1:0]   ctrOut,
  output logic               pwmOut,
  output logic               tripFlag,
  output logic               periodIrq
);
  tbEvt_t tbEvt;

  pwm_timebase #(.CNT_W(CNT_W)) uTimebase (
    .clk       (clk),
    .rstN      (rstN),
    .periodIn  (periodIn),
    .compareIn (compareIn),
    .ctr       (ctrOut),
    .evt       (tbEvt)
  );

  pwm_control #(.PRESC_W(PRESC_W)) uControl (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (tbEvt),
    .tripIn       (tripIn),
    .tripForce    (tripForce),
    .tripAction   (tripAction),
    .swForce      (swForce),
    .swForceLevel (swForceLevel),
    .tripFlagClr  (tripFlagClr),
    .intEnable    (intEnable),
    .intPrescale  (intPrescale),
    .pwmOut       (pwmOut),
    .tripFlag     (tripFlag),
    .periodIrq    (periodIrq)
  );
endmodule

// File: tb/tb_updn_pwm_trip.sv
module tb_updn_pwm_trip;
  localparam int CNT_W   = 8;
  localparam int PRESC_W = 2;

  logic               clk = 1'b0;
  logic               rstN;
  logic [CNT_W-1:0]   periodIn;
  logic [CNT_W-1:0]   compareIn;
  logic               tripIn, tripForce, swForce, swForceLevel, tripFlagClr, intEnable;
  logic [1:0]         tripAction;
  logic [PRESC_W-1:0] intPrescale;
  logic [CNT_W-1:0]   ctrOut;
  logic               pwmOut, tripFlag, periodIrq;

  int nChecks = 0;
  int nErr    = 0;
  int t       = 0;
  int maxSeen = 0;

  updn_pwm_trip #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) dut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .compareIn(compareIn),
    .tripIn(tripIn), .tripForce(tripForce), .tripAction(tripAction),
    .swForce(swForce), .swForceLevel(swForceLevel), .tripFlagClr(tripFlagClr),
    .intEnable(intEnable), .intPrescale(intPrescale),
    .ctrOut(ctrOut), .pwmOut(pwmOut), .tripFlag(tripFlag), .periodIrq(periodIrq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s at t=%0d: actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  function automatic int triv(input int tt, input int p);
    int m = tt % (2 * p);
    return (m <= p) ? m : (2 * p - m);
  endfunction

  function automatic int expPwm(input int tt, input int p, input int c);
    int m = tt % (2 * p);
    return ((m > c) && (m <= 2 * p - c)) ? 1 : 0;
  endfunction

  task automatic adv();
    @(negedge clk);
    t++;
  endtask

  task automatic waitT(input int n);
    while (t < n) adv();
  endtask

  // Align to the clock after a zero: t = 1 there
  task automatic syncStart();
    maxSeen = 0;
    do begin
      @(negedge clk);
      if (int'(ctrOut) > maxSeen) maxSeen = int'(ctrOut);
    end while (ctrOut != '0);
    @(negedge clk);
    t = 1;
    chk("R1 start", int'(ctrOut), 1);
  endtask

  initial begin
    #2ms;
    nErr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int oldP;
    rstN = 1'b0; periodIn = 8'd2; compareIn = 8'd1;
    tripIn = 0; tripForce = 0; swForce = 0; swForceLevel = 0;
    tripFlagClr = 0; intEnable = 0; tripAction = 2'b00; intPrescale = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ctr", int'(ctrOut), 0);
    chk("R10 pwm", int'(pwmOut), 0);
    chk("R10 flag", int'(tripFlag), 0);
    chk("R10 irq", int'(periodIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 ctr after release", int'(ctrOut), 0);
    chk("R10 pwm after release", int'(pwmOut), 0);

    // R1 R2 R3 sweep over period and compare
    oldP = 0;
    for (int p = 2; p <= 7; p++) begin
      for (int c = 1; c < p; c++) begin
        periodIn  = CNT_W'(p);
        compareIn = CNT_W'(c);
        syncStart();
        if (oldP != 0) chk("R2 old peak kept", maxSeen, oldP);
        for (int k = 1; k <= 4 * p; k++) begin
          chk("R1 triangle", int'(ctrOut), triv(t, p));
          chk("R3 pwm shape", int'(pwmOut), expPwm(t, p, c));
          adv();
        end
        oldP = p;
      end
    end

    // R4 software force, P=6 C=2
    periodIn = 8'd6; compareIn = 8'd2;
    syncStart();
    syncStart();
    swForce = 1; swForceLevel = 1;
    adv(); swForce = 0;
    chk("R4 force high", int'(pwmOut), 1);
    waitT(11);
    chk("R4 compare clears after force", int'(pwmOut), 0);
    swForce = 1; swForceLevel = 1;
    adv(); swForce = 0;
    chk("R4 force high in low region", int'(pwmOut), 1);
    waitT(23);
    chk("R4 next clear match wins", int'(pwmOut), 0);
    waitT(27);
    swForce = 1; swForceLevel = 0;
    adv(); swForce = 0;
    chk("R4 force low in high region", int'(pwmOut), 0);
    waitT(39);
    chk("R4 next set match wins", int'(pwmOut), 1);

    // R5 R6 R7 trip forcing high
    syncStart();
    tripAction = 2'b01;
    waitT(2);
    tripForce = 1;
    adv(); tripForce = 0;
    chk("R5 trip high", int'(pwmOut), 1);
    chk("R7 flag set", int'(tripFlag), 1);
    waitT(12);
    chk("R6 held through zero clock", int'(pwmOut), 1);
    adv();
    chk("R6 released after zero", int'(pwmOut), 0);
    chk("R7 flag held", int'(tripFlag), 1);
    tripFlagClr = 1;
    adv(); tripFlagClr = 0;
    chk("R7 flag cleared", int'(tripFlag), 0);

    // R5 R6 trip forcing low, level input held across a zero
    tripAction = 2'b10;
    tripIn = 1;
    adv();
    chk("R5 trip low", int'(pwmOut), 0);
    chk("R7 flag from tripIn", int'(tripFlag), 1);
    waitT(27);
    chk("R6 re-latched at zero", int'(pwmOut), 0);
    tripIn = 0;
    waitT(30);
    chk("R6 latch kept until zero", int'(pwmOut), 0);
    waitT(39);
    chk("R6 normal after second zero", int'(pwmOut), 1);

    // R5 no-change action
    tripAction = 2'b00;
    tripForce = 1;
    adv(); tripForce = 0;
    chk("R5 code 00 no override", int'(pwmOut), 1);
    waitT(47);
    chk("R5 code 00 clear still acts", int'(pwmOut), 0);
    tripAction = 2'b11;
    waitT(51);
    tripForce = 1;
    adv(); tripForce = 0;
    chk("R5 code 11 no override", int'(pwmOut), 1);
    tripFlagClr = 1;
    adv(); tripFlagClr = 0;

    // R8 R9 prescaled period interrupt, events at t = 6 mod 12
    intPrescale = 2'd3;
    syncStart();
    intEnable = 1;
    for (int k = 1; k <= 69; k++) begin
      chk("R8 every third", int'(periodIrq), (t == 31 || t == 67) ? 1 : 0);
      adv();
    end
    waitT(80);
    intEnable = 0;
    adv(); intEnable = 1;
    while (t < 120) begin
      chk("R9 count reset by disable", int'(periodIrq), (t == 115) ? 1 : 0);
      adv();
    end
    intPrescale = 2'd1;
    adv();
    while (t < 141) begin
      chk("R8 every event", int'(periodIrq), (t == 127 || t == 139) ? 1 : 0);
      adv();
    end
    intPrescale = 2'd0;
    while (t < 175) begin
      chk("R8 prescale 0 silent", int'(periodIrq), 0);
      adv();
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule